// File: doc/BRIEF.md
# Ratio Clock-Enable Divider with Dual Source Select

This block divides a stream of source clock-enable ticks by an integer ratio and emits one output enable pulse every N ticks. Two tick sources feed it: a crystal-rate tick and a reference-rate tick. A source-select bit in the configuration register decides which stream is counted. Each source has its own divider field, so switching sources also switches the ratio in use. A gate bit silences the output without stopping the count.

Software changes the ratio by writing the register. The block does not apply a new ratio at once. It waits until the running division reaches its terminal tick, then loads the new value. A read-only busy bit stays high from the write until one cycle after that load, so software can poll it. Writes go through one of four aliases: plain store, set-bits, clear-bits and toggle-bits. A divider field that a write would leave at zero keeps its old value. A mode bit for fractional operation is stored and can be read back, but the divider always works as a pure integer divider.

Top module: `ratio_clkdiv`

## Requirements
- R1: After reset, `rd_data` reads 16'h0412: gate 0 (bit 0), source select 1 (bit 1), fractional mode 0 (bit 2), busy 0 (bit 3), crystal divider 1 (bits 9:4) and reference divider 1 (bits 15:10).
- R2: `wr_op` picks the write alias: 0 stores `wr_data`, 1 sets the bits written as 1, 2 clears the bits written as 1, and 3 inverts the bits written as 1. Bits written as 0 are left unchanged under aliases 1 to 3.
- R3: Bit 3 is read-only. Writing it has no effect on the value read back.
- R4: A write that would leave a divider field at zero keeps that field's previous value, while the other fields still update. Such a write raises no busy.
- R5: Source select 1 counts `xtal_tick` and source select 0 counts `ref_tick`. Ticks on the source that is not selected have no effect.
- R6: With N as the ratio in effect, `div_tick` is high in the same cycle as every Nth selected tick.
- R7: Gate 1 holds `div_tick` low. The count keeps advancing while the gate is set.
- R8: When the divider of the selected source differs from the ratio in effect, busy reads 1. The new ratio loads on the next terminal tick of the old ratio, and busy reads 0 from the second cycle after that tick.
- R9: Fractional mode (bit 2) is stored and can be read back, and it has no effect on the division.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| xtal_tick | input | 1 | Crystal-source tick enable |
| ref_tick | input | 1 | Reference-source tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_op | input | 2 | Write alias: 0 store, 1 set, 2 clear, 3 toggle |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Register contents including busy |
| div_tick | output | 1 | Divided output enable pulse |

## Verification
A register write and the selected source's terminal tick can arrive in the same cycle. The test drives a write of a new reference ratio together with a reference tick that ends the current division. It checks three things: the pulse for that cycle still follows the old ratio, the write sets busy, and the new ratio loads only at the next terminal tick. Busy must then clear exactly one cycle after that load.

// File: rtl/rcd_pkg.sv
package rcd_pkg;
  typedef enum logic [1:0] {
    WR_STORE = 2'd0,
    WR_SET   = 2'd1,
    WR_CLEAR = 2'd2,
    WR_FLIP  = 2'd3
  } wr_alias_e;

  localparam int POS_GATE  = 0;
  localparam int POS_SRC   = 1;
  localparam int POS_FRAC  = 2;
  localparam int POS_BUSY  = 3;
  localparam int POS_FIELD = 4;
endpackage

// File: rtl/rcd_cfg_reg.sv
module rcd_cfg_reg
  import rcd_pkg::*;
#(
  parameter int DIV_W = 6,
  localparam int REG_W = POS_FIELD + 2 * DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_op,
  input  logic [REG_W-1:0] wr_data,
  output logic             gate,
  output logic             src_xtal,
  output logic             frac_mode,
  output logic [DIV_W-1:0] xdiv,
  output logic [DIV_W-1:0] rdiv
);
  logic             gate_q, src_q, frac_q;
  logic [DIV_W-1:0] xdiv_q, rdiv_q;
  logic             gate_d, src_d, frac_d;
  logic [DIV_W-1:0] xdiv_d, rdiv_d;
  logic [REG_W-1:0] cur, cand;
  logic [DIV_W-1:0] x_c, r_c;

  always_comb begin
    cur = {rdiv_q, xdiv_q, 1'b0, frac_q, src_q, gate_q};
    unique case (wr_alias_e'(wr_op))
      WR_STORE: cand = wr_data;
      WR_SET:   cand = cur | wr_data;
      WR_CLEAR: cand = cur & ~wr_data;
      default:  cand = cur ^ wr_data;
    endcase
    x_c    = cand[POS_FIELD +: DIV_W];
    r_c    = cand[POS_FIELD + DIV_W +: DIV_W];
    gate_d = cand[POS_GATE];
    src_d  = cand[POS_SRC];
    frac_d = cand[POS_FRAC];
    xdiv_d = (x_c == '0) ? xdiv_q : x_c;
    rdiv_d = (r_c == '0) ? rdiv_q : r_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      src_q  <= 1'b1;
      frac_q <= 1'b0;
      xdiv_q <= DIV_W'(1);
      rdiv_q <= DIV_W'(1);
    end else if (wr_en) begin
      gate_q <= gate_d;
      src_q  <= src_d;
      frac_q <= frac_d;
      xdiv_q <= xdiv_d;
      rdiv_q <= rdiv_d;
    end
  end

  assign gate      = gate_q;
  assign src_xtal  = src_q;
  assign frac_mode = frac_q;
  assign xdiv      = xdiv_q;
  assign rdiv      = rdiv_q;
endmodule

// File: rtl/rcd_counter.sv
module rcd_counter #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_tick,
  input  logic             gate,
  input  logic [DIV_W-1:0] target,
  output logic             div_tick,
  output logic             busy
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] act_q, act_d;
  logic             applied_q, applied_d;
  logic             terminal, load;

  always_comb begin
    terminal  = (cnt_q == act_q - DIV_W'(1));
    load      = sel_tick && terminal && (target != act_q);
    cnt_d     = cnt_q;
    act_d     = act_q;
    applied_d = load;
    if (sel_tick) begin
      cnt_d = terminal ? '0 : cnt_q + DIV_W'(1);
    end
    if (load) begin
      act_d = target;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      act_q     <= DIV_W'(1);
      applied_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      act_q     <= act_d;
      applied_q <= applied_d;
    end
  end

  assign div_tick = sel_tick && terminal && !gate;
  assign busy     = (target != act_q) || applied_q;
endmodule

// File: rtl/ratio_clkdiv.sv
module ratio_clkdiv
  import rcd_pkg::*;
#(
  parameter int DIV_W = 6,
  localparam int REG_W = POS_FIELD + 2 * DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xtal_tick,
  input  logic             ref_tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_op,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             div_tick
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_i;
  logic             gate, src_xtal, frac_mode, busy, sel_tick;
  logic [DIV_W-1:0] xdiv, rdiv, target;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  rcd_cfg_reg #(.DIV_W(DIV_W)) u_cfg (
    .clk(clk), .rst_n(rst_n_i), .wr_en(wr_en), .wr_op(wr_op), .wr_data(wr_data),
    .gate(gate), .src_xtal(src_xtal), .frac_mode(frac_mode), .xdiv(xdiv), .rdiv(rdiv)
  );

  assign sel_tick = src_xtal ? xtal_tick : ref_tick;
  assign target   = src_xtal ? xdiv : rdiv;

  rcd_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_i), .sel_tick(sel_tick), .gate(gate),
    .target(target), .div_tick(div_tick), .busy(busy)
  );

  assign rd_data = {rdiv, xdiv, busy, frac_mode, src_xtal, gate};
endmodule

// File: rtl/ratio_clkdiv_chk.sv
module ratio_clkdiv_chk #(
  parameter int DIV_W = 6,
  localparam int REG_W = 4 + 2 * DIV_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xtal_tick,
  input logic             ref_tick,
  input logic             wr_en,
  input logic [1:0]       wr_op,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             div_tick
);
  AST_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_op == 2'd1) |=> ((rd_data[2:0] & $past(wr_data[2:0])) == $past(wr_data[2:0]))); // R2
  AST_CLEAR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_op == 2'd2) |=> ((rd_data[2:0] & $past(wr_data[2:0])) == 3'b000)); // R2
  AST_FLIP_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_op == 2'd3) |=> (rd_data[2:0] == $past(rd_data[2:0] ^ wr_data[2:0]))); // R2
  AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[4 +: DIV_W] != '0) && (rd_data[4 + DIV_W +: DIV_W] != '0)); // R4
  AST_SOURCE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |-> (rd_data[1] ? xtal_tick : ref_tick)); // R5
  AST_GATE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[0] |-> !div_tick); // R7
endmodule

bind ratio_clkdiv ratio_clkdiv_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n_i), .xtal_tick(xtal_tick), .ref_tick(ref_tick),
  .wr_en(wr_en), .wr_op(wr_op), .wr_data(wr_data), .rd_data(rd_data), .div_tick(div_tick)
);

// File: tb/test_ratio_clkdiv.sv
module test_ratio_clkdiv;
  localparam int PERIOD = 10;
  localparam int DIV_W  = 6;
  localparam int REG_W  = 4 + 2 * DIV_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             xtal_tick, ref_tick, wr_en;
  logic [1:0]       wr_op;
  logic [REG_W-1:0] wr_data;
  logic [REG_W-1:0] rd_data;
  logic             div_tick;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // {op, write data, expected read-back}; no ticks, so busy follows the fields only
  localparam logic [33:0] VEC [0:8] = '{
    {2'd1, 16'h0001, 16'h0413},   // R2 set gate
    {2'd2, 16'h0001, 16'h0412},   // R2 clear gate
    {2'd1, 16'h0004, 16'h0416},   // R9 fractional mode stored
    {2'd3, 16'h0006, 16'h0410},   // R2 flip source and mode
    {2'd3, 16'h0002, 16'h0412},   // R2 flip source back
    {2'd1, 16'h0008, 16'h0412},   // R3 busy bit read-only
    {2'd0, 16'h0000, 16'h0410},   // R4 zero fields kept
    {2'd2, 16'h03F0, 16'h0410},   // R4 clearing crystal field ignored
    {2'd0, 16'h0412, 16'h0412}    // R2 plain store
  };

  ratio_clkdiv #(.DIV_W(DIV_W)) i_ratio_clkdiv (
    .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .ref_tick(ref_tick),
    .wr_en(wr_en), .wr_op(wr_op), .wr_data(wr_data), .rd_data(rd_data), .div_tick(div_tick)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] op, input logic [REG_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_op = op; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_ticks(input bit use_x, input int n, output int pulses, output bit last);
    pulses = 0; last = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      xtal_tick = use_x; ref_tick = !use_x;
      #1;
      if (div_tick) pulses++;
      last = div_tick;
      @(negedge clk);
      xtal_tick = 1'b0; ref_tick = 1'b0;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int p;
    bit l;
    rst_n = 1'b0; xtal_tick = 1'b0; ref_tick = 1'b0;
    wr_en = 1'b0; wr_op = 2'd0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rd_data == 16'h0412, "R1 reset value", rd_data, 16'h0412);
    chk(div_tick == 1'b0, "R1 no pulse after reset", div_tick, 0);

    for (int i = 0; i < 9; i++) begin
      do_write(VEC[i][33:32], VEC[i][31:16]);
      chk(rd_data == VEC[i][15:0], "R2/R3/R4/R9 table write", rd_data, VEC[i][15:0]);
    end

    // R8 crystal ratio 1 -> 3
    do_write(2'd0, 16'h0432);
    chk(rd_data == 16'h043A, "R8 busy after ratio write", rd_data, 16'h043A);
    run_ticks(1'b1, 1, p, l);
    chk(p == 1, "R8 old ratio holds until terminal", p, 1);
    chk(rd_data[3] == 1'b1, "R8 busy in cycle after load", rd_data[3], 1);
    @(negedge clk);
    chk(rd_data[3] == 1'b0, "R8 busy cleared", rd_data[3], 0);
    run_ticks(1'b1, 6, p, l);
    chk(p == 2 && l, "R6 divide by 3", p, 2);

    // R5 unselected source ignored
    run_ticks(1'b0, 5, p, l);
    chk(p == 0, "R5 reference ticks ignored", p, 0);

    // R7 gate silences, count continues
    do_write(2'd1, 16'h0001);
    run_ticks(1'b1, 3, p, l);
    chk(p == 0, "R7 gated output", p, 0);
    do_write(2'd2, 16'h0001);
    run_ticks(1'b1, 3, p, l);
    chk(p == 1 && l, "R7 count advanced while gated", p, 1);

    // R5/R8 switch to reference source with ratio 1
    do_write(2'd3, 16'h0002);
    chk(rd_data == 16'h0438, "R8 busy on source switch", rd_data, 16'h0438);
    run_ticks(1'b0, 3, p, l);
    chk(p == 1 && l, "R8 old ratio on new source", p, 1);
    @(negedge clk);
    chk(rd_data[3] == 1'b0, "R8 busy cleared after switch", rd_data[3], 0);
    run_ticks(1'b0, 4, p, l);
    chk(p == 4, "R6 divide by 1", p, 4);
    run_ticks(1'b1, 3, p, l);
    chk(p == 0, "R5 crystal ticks ignored", p, 0);

    // R9 fractional mode has no effect
    do_write(2'd1, 16'h0004);
    run_ticks(1'b0, 4, p, l);
    chk(p == 4, "R9 mode bit no effect", p, 4);

    // R4 zero reference field, no busy
    do_write(2'd0, 16'h0030);
    chk(rd_data == 16'h0430, "R4 zero field kept no busy", rd_data, 16'h0430);

    // write and terminal tick in the same cycle
    @(negedge clk);
    wr_en = 1'b1; wr_op = 2'd0; wr_data = 16'h0830; ref_tick = 1'b1;
    #1;
    chk(div_tick == 1'b1, "R8 same-cycle pulse uses old ratio", div_tick, 1);
    @(negedge clk);
    wr_en = 1'b0; ref_tick = 1'b0;
    chk(rd_data == 16'h0838, "R8 same-cycle write sets busy", rd_data, 16'h0838);
    run_ticks(1'b0, 1, p, l);
    chk(p == 1, "R8 load at next terminal", p, 1);
    chk(rd_data[3] == 1'b1, "R8 busy one cycle after load", rd_data[3], 1);
    @(negedge clk);
    chk(rd_data[3] == 1'b0, "R8 busy drops", rd_data[3], 0);
    run_ticks(1'b0, 4, p, l);
    chk(p == 2 && l, "R6 divide by 2", p, 2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule